// File: doc/BRIEF.md
# Bus-Sequenced Accumulator CPU

A small teaching processor built around one 8-bit internal bus. It contains an accumulator A, an operand register B, an instruction register, a memory address register, a 4-bit program counter, a 16-byte memory, an add/subtract ALU with zero and carry flags, and an output register. A microcode sequencer picks one bus driver and a set of load strobes for every microstep. It indexes the microcode by opcode, step number and flag state.

The memory is filled through a dedicated write port while the core is held in reset or stalled. The core then runs one microstep per clock edge while `stepEn` is high. The visible result is the output register. A halt flag rises when the program executes its halt instruction. Only a reset leaves the halted state.

Top module: `acc_cpu8`

## Requirements
- R1: An instruction byte holds the opcode in bits 7:4 and a 4-bit operand in bits 3:0. The opcodes are NOP=0, LDA=1, ADD=2, SUB=3, STA=4, LDI=5, JMP=6, JC=7, JZ=8, OUT=0xE and HLT=0xF. Any other opcode behaves as NOP.
- R2: After reset, `outVal` is 0, `halted` is 0, the program counter, A, B and both flags are 0, and execution starts at address 0. Memory is not cleared.
- R3: Every instruction begins with two fetch steps. The first moves the PC into the address register. The second loads the instruction register from memory and increments the PC, wrapping from 15 to 0. No instruction runs longer than 5 steps.
- R4: LDA loads A from memory in 4 cycles. LDI loads the zero-extended operand into A in 3 cycles. STA writes A to memory in 4 cycles. NOP takes 3 cycles.
- R5: ADD and SUB take 5 cycles and write A+B or A-B modulo 256 into A. Z is set when the result is 0. C is the carry out of bit 7 of A + B, or of A + ~B + 1 for SUB, so C=1 means no borrow.
- R6: Only ADD and SUB change the flags. Every other instruction leaves them unchanged.
- R7: JMP loads the PC from the operand. JC and JZ do the same only when C or Z is set, and otherwise fall through. Each jump takes 3 cycles whether or not it is taken.
- R8: OUT copies A to `outVal` in 3 cycles. No other instruction changes `outVal`.
- R9: HLT raises `halted` on its third cycle. From then on the PC, step, `outVal` and `halted` stay frozen until reset.
- R10: While `stepEn` is low, no microstep advances and no core state changes. A run that is stalled finishes with the same result after the same number of enabled cycles.
- R11: At most one source drives the internal bus in any cycle.
- R12: The write port stores `memWrData` at `memWrAddr` on any clock edge where `memWrEn` is high. LDA, ADD and SUB then read those contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stepEn | input | 1 | Advance one microstep per edge when high |
| memWrEn | input | 1 | Memory write port enable |
| memWrAddr | input | 4 | Memory write port address |
| memWrData | input | 8 | Memory write port data |
| outVal | output | 8 | Output register |
| halted | output | 1 | High after HLT executes |

## Verification
Every result is timed in enabled clock edges counted from reset release. The arithmetic test program (LDA, ADD or SUB, OUT) places its result on `outVal` after exactly 12 edges. `halted` rises after 21, 24 or 27 edges, depending on which conditional branch was taken. The bench drives inputs and samples outputs on the falling edge, and counts only the edges where `stepEn` is high. It compares the value sampled at the computed edge and the exact edge count at halt against expected values from bench functions. The stall test holds `stepEn` low for several cycles and checks that `outVal` and `halted` do not move and that the enabled-edge count stays unchanged.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int OPC_W  = 4;
  localparam int STEP_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP = 4'h0, OP_LDA = 4'h1, OP_ADD = 4'h2, OP_SUB = 4'h3,
    OP_STA = 4'h4, OP_LDI = 4'h5, OP_JMP = 4'h6, OP_JC  = 4'h7,
    OP_JZ  = 4'h8, OP_OUT = 4'hE, OP_HLT = 4'hF
  } opcode_e;

  // bus driver selects, one-hot or none
  typedef struct packed {
    logic pcOut;
    logic memOut;
    logic irOut;
    logic aOut;
    logic aluOut;
  } drive_t;

  typedef struct packed {
    drive_t drv;
    logic   marIn;
    logic   memIn;
    logic   irIn;
    logic   aIn;
    logic   bIn;
    logic   outIn;
    logic   pcIn;
    logic   pcInc;
    logic   aluSub;
    logic   flagIn;
    logic   halt;
    logic   done;
  } ctrl_t;
endpackage

// File: rtl/cpu_control.sv
module cpu_control
  import cpu_pkg::*;
#(
  parameter int STEPW     = STEP_W,
  parameter int LAST_STEP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stepEn,
  input  logic [OPC_W-1:0] opcode,
  input  logic             flagC,
  input  logic             flagZ,
  output ctrl_t            ctrl,
  output logic             halted,
  output logic [STEPW-1:0] step
);
  localparam logic [STEPW-1:0] LAST = STEPW'(LAST_STEP);

  logic  haltReg;
  logic  live;
  ctrl_t rawWord;

  function automatic ctrl_t microword(input logic [OPC_W-1:0] op,
                                      input logic [STEPW-1:0] st,
                                      input logic c, input logic z);
    ctrl_t m;
    m = '0;
    case (st)
      STEPW'(0): begin m.drv.pcOut = 1'b1; m.marIn = 1'b1; end
      STEPW'(1): begin m.drv.memOut = 1'b1; m.irIn = 1'b1; m.pcInc = 1'b1; end
      STEPW'(2): begin
        case (opcode_e'(op))
          OP_LDA, OP_ADD, OP_SUB, OP_STA: begin
            m.drv.irOut = 1'b1; m.marIn = 1'b1;
          end
          OP_LDI: begin m.drv.irOut = 1'b1; m.aIn = 1'b1; m.done = 1'b1; end
          OP_JMP: begin m.drv.irOut = 1'b1; m.pcIn = 1'b1; m.done = 1'b1; end
          OP_JC: begin
            m.drv.irOut = c; m.pcIn = c; m.done = 1'b1;
          end
          OP_JZ: begin
            m.drv.irOut = z; m.pcIn = z; m.done = 1'b1;
          end
          OP_OUT: begin m.drv.aOut = 1'b1; m.outIn = 1'b1; m.done = 1'b1; end
          OP_HLT: m.halt = 1'b1;
          default: m.done = 1'b1;
        endcase
      end
      STEPW'(3): begin
        case (opcode_e'(op))
          OP_LDA: begin m.drv.memOut = 1'b1; m.aIn = 1'b1; m.done = 1'b1; end
          OP_ADD, OP_SUB: begin m.drv.memOut = 1'b1; m.bIn = 1'b1; end
          OP_STA: begin m.drv.aOut = 1'b1; m.memIn = 1'b1; m.done = 1'b1; end
          default: m.done = 1'b1;
        endcase
      end
      STEPW'(4): begin
        if (op == OP_ADD || op == OP_SUB) begin
          m.drv.aluOut = 1'b1;
          m.aIn        = 1'b1;
          m.flagIn     = 1'b1;
          m.aluSub     = (op == OP_SUB);
        end
        m.done = 1'b1;
      end
      default: m.done = 1'b1;
    endcase
    return m;
  endfunction

  assign live    = stepEn && !haltReg;
  assign rawWord = microword(opcode, step, flagC, flagZ);
  assign ctrl    = live ? rawWord : '0;
  assign halted  = haltReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      step    <= '0;
      haltReg <= 1'b0;
    end else if (live) begin
      if (rawWord.halt)
        haltReg <= 1'b1;
      else if (rawWord.done || step == LAST)
        step <= '0;
      else
        step <= step + 1'b1;
    end
  end
endmodule

// File: rtl/cpu_datapath.sv
module cpu_datapath
  import cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic              memWrEn,
  input  logic [ADDR_W-1:0] memWrAddr,
  input  logic [DATA_W-1:0] memWrData,
  output logic [OPC_W-1:0]  opcode,
  output logic              flagC,
  output logic              flagZ,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] outVal
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] ir, regA, regB, busVal, memRd, aluRes;
  logic [DATA_W-1:0] pcExt, irExt, bOperand;
  logic              aluCarry;
  logic [DATA_W-1:0] mem [DEPTH];

  assign pcExt    = DATA_W'(pc);
  assign irExt    = DATA_W'(ir[ADDR_W-1:0]);
  assign memRd    = mem[mar];
  assign bOperand = ctrl.aluSub ? ~regB : regB;
  assign {aluCarry, aluRes} = {1'b0, regA} + {1'b0, bOperand} + (DATA_W+1)'(ctrl.aluSub);

  // one-hot AND-OR bus mux
  assign busVal = ({DATA_W{ctrl.drv.pcOut}}  & pcExt)
                | ({DATA_W{ctrl.drv.memOut}} & memRd)
                | ({DATA_W{ctrl.drv.irOut}}  & irExt)
                | ({DATA_W{ctrl.drv.aOut}}   & regA)
                | ({DATA_W{ctrl.drv.aluOut}} & aluRes);

  assign opcode = ir[DATA_W-1 -: OPC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      mar    <= '0;
      ir     <= '0;
      regA   <= '0;
      regB   <= '0;
      outVal <= '0;
      flagC  <= 1'b0;
      flagZ  <= 1'b0;
    end else begin
      if (ctrl.marIn) mar  <= busVal[ADDR_W-1:0];
      if (ctrl.irIn)  ir   <= busVal;
      if (ctrl.aIn)   regA <= busVal;
      if (ctrl.bIn)   regB <= busVal;
      if (ctrl.outIn) outVal <= busVal;
      if (ctrl.pcIn)       pc <= busVal[ADDR_W-1:0];
      else if (ctrl.pcInc) pc <= pc + 1'b1;
      if (ctrl.flagIn) begin
        flagC <= aluCarry;
        flagZ <= (aluRes == '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (memWrEn)         mem[memWrAddr] <= memWrData;
    else if (ctrl.memIn) mem[mar]       <= busVal;
  end
endmodule

// File: rtl/acc_cpu8.sv
module acc_cpu8
  import cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stepEn,
  input  logic              memWrEn,
  input  logic [ADDR_W-1:0] memWrAddr,
  input  logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] outVal,
  output logic              halted
);
  ctrl_t             ctrl;
  logic [OPC_W-1:0]  opcode;
  logic              flagC, flagZ;
  logic [ADDR_W-1:0] pc;
  logic [STEP_W-1:0] step;

  cpu_control #(.STEPW(STEP_W), .LAST_STEP(4)) u_ctrl (
    .clk(clk), .rst(rst), .stepEn(stepEn), .opcode(opcode),
    .flagC(flagC), .flagZ(flagZ), .ctrl(ctrl), .halted(halted), .step(step)
  );

  cpu_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .opcode(opcode),
    .flagC(flagC), .flagZ(flagZ), .pc(pc), .outVal(outVal)
  );
endmodule

// File: rtl/cpu_checker.sv
module cpu_checker
  import cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              stepEn,
  input ctrl_t             ctrl,
  input logic [STEP_W-1:0] step,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] outVal,
  input logic              halted
);
  assert_bus_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl.drv));

  assert_step_range_R3: assert property (@(posedge clk) disable iff (rst)
    step <= STEP_W'(4));

  assert_fetch_advance_R3: assert property (@(posedge clk) disable iff (rst)
    (stepEn && !halted && step == '0) |=> (step == STEP_W'(1)));

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  assert_halt_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(outVal) && $stable(pc) && $stable(step)));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !stepEn |=> ($stable(outVal) && $stable(pc) && $stable(step) && $stable(halted)));

  assert_out_only_by_out_R8: assert property (@(posedge clk) disable iff (rst)
    !ctrl.outIn |=> $stable(outVal));
endmodule

bind acc_cpu8 cpu_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .stepEn(stepEn), .ctrl(ctrl), .step(step),
  .pc(pc), .outVal(outVal), .halted(halted)
);

// File: tb/sim_acc_cpu8.sv
module sim_acc_cpu8;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stepEn = 1'b0;
  logic       memWrEn = 1'b0;
  logic [3:0] memWrAddr = '0;
  logic [7:0] memWrData = '0;
  logic [7:0] outVal;
  logic       halted;

  int checks = 0;
  int errors = 0;
  logic [7:0] image [16];

  always #10 clk = ~clk;  // 50 MHz

  acc_cpu8 u0 (
    .clk(clk), .rst(rst), .stepEn(stepEn), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .outVal(outVal), .halted(halted)
  );

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // hold reset, load the image through the write port, release
  task automatic loadAndStart();
    @(negedge clk);
    rst = 1'b1; stepEn = 1'b0;
    for (int i = 0; i < 16; i++) begin
      memWrEn = 1'b1; memWrAddr = 4'(i); memWrData = image[i];
      @(negedge clk);
    end
    memWrEn = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // counts enabled edges until halted; samples outVal after sampleAt edges;
  // optionally stalls for 4 cycles after stallAt edges
  task automatic run(input int sampleAt, input int stallAt, output int n,
                     output logic [7:0] sampled, input string req);
    logic [7:0] held;
    n = 0; sampled = '0;
    stepEn = 1'b1;
    while (n < 100) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == sampleAt) sampled = outVal;
      if (halted) break;
      if (n == stallAt) begin
        stepEn = 1'b0; held = outVal;
        for (int k = 0; k < 4; k++) @(negedge clk);
        chk({req, " R10 outVal held during stall"}, int'(outVal), int'(held));
        chk({req, " R10 halted low during stall"}, int'(halted), 0);
        stepEn = 1'b1;
      end
    end
    stepEn = 1'b0;
  endtask

  function automatic logic [7:0] arithRes(input logic [7:0] x, y, input bit sub);
    return sub ? 8'(x - y) : 8'(x + y);
  endfunction
  function automatic bit arithC(input logic [7:0] x, y, input bit sub);
    return sub ? (x >= y) : ((int'(x) + int'(y)) > 255);
  endfunction
  function automatic logic [7:0] arithFinal(input logic [7:0] x, y, input bit sub);
    logic [7:0] r = arithRes(x, y, sub);
    return arithC(x, y, sub) ? 8'd1 : (r == 0) ? 8'd2 : r;
  endfunction
  function automatic int arithCycles(input logic [7:0] x, y, input bit sub);
    return arithC(x, y, sub) ? 24 : (arithRes(x, y, sub) == 0) ? 27 : 21;
  endfunction

  task automatic arithTest(input logic [7:0] x, y, input bit sub, input string tag);
    int n; logic [7:0] s;
    for (int i = 0; i < 16; i++) image[i] = 8'h00;
    image[0] = 8'h1E; image[1] = sub ? 8'h3F : 8'h2F; image[2] = 8'hE0;
    image[3] = 8'h76; image[4] = 8'h8A; image[5] = 8'hF0;
    image[6] = 8'h51; image[7] = 8'hE0; image[8] = 8'hF0;
    image[10] = 8'h52; image[11] = 8'hE0; image[12] = 8'hF0;
    image[14] = x; image[15] = y;
    loadAndStart();
    run(12, 0, n, s, tag);
    chk({tag, " R5 R12 result on outVal after 12 cycles"}, int'(s), int'(arithRes(x, y, sub)));
    chk({tag, " R7 branch outcome on outVal"}, int'(outVal), int'(arithFinal(x, y, sub)));
    chk({tag, " R9 cycles to halt"}, n, arithCycles(x, y, sub));
  endtask

  initial begin
    int n; logic [7:0] s;
    void'($urandom(32'd1234));

    for (int i = 0; i < 16; i++) image[i] = 8'hF0;
    loadAndStart();
    chk("R2 outVal after reset", int'(outVal), 0);
    chk("R2 halted after reset", int'(halted), 0);
    run(0, 0, n, s, "R1 halt at address 0");
    chk("R9 HLT at address 0 halts in 3 cycles", n, 3);
    chk("R9 outVal unchanged by HLT", int'(outVal), 0);

    arithTest(8'd200, 8'd100, 1'b0, "R5 add carry wrap");
    arithTest(8'd0, 8'd0, 1'b0, "R5 add zero");
    arithTest(8'd5, 8'd5, 1'b1, "R5 sub equal");
    arithTest(8'd3, 8'd9, 1'b1, "R5 sub borrow");
    arithTest(8'd255, 8'd1, 1'b0, "R5 add to zero");
    arithTest(8'd17, 8'd25, 1'b0, "R5 add plain");

    @(negedge clk); rst = 1'b1; @(negedge clk);
    chk("R2 outVal cleared by reset after run", int'(outVal), 0);
    chk("R2 halted cleared by reset", int'(halted), 0);

    // R4 R6: LDI 0 leaves Z clear, so JZ falls through
    for (int i = 0; i < 16; i++) image[i] = 8'h00;
    image[0] = 8'h50; image[1] = 8'h85; image[2] = 8'h59; image[3] = 8'h4F;
    image[4] = 8'h1F; image[5] = 8'h2F; image[6] = 8'hE0; image[7] = 8'hF0;
    image[15] = 8'd3;
    loadAndStart();
    run(0, 0, n, s, "R4");
    chk("R4 R6 LDI STA LDA ADD result", int'(outVal), 18);
    chk("R4 R6 cycle count", n, 28);

    // R3 R7: JMP, PC wrap 15->0, JZ taken after SUB to zero
    for (int i = 0; i < 16; i++) image[i] = 8'h00;
    image[0] = 8'h84; image[1] = 8'h6E; image[4] = 8'hE0; image[5] = 8'hF0;
    image[13] = 8'h00; image[14] = 8'h3D; image[15] = 8'h56;
    loadAndStart();
    run(0, 0, n, s, "R3");
    chk("R3 R7 wrap and JZ taken output", int'(outVal), 6);
    chk("R3 R7 cycle count", n, 23);

    // R10 stall in the middle of an ADD
    for (int i = 0; i < 16; i++) image[i] = 8'h00;
    image[0] = 8'h1E; image[1] = 8'h2F; image[2] = 8'hE0;
    image[3] = 8'h76; image[4] = 8'h8A; image[5] = 8'hF0;
    image[6] = 8'h51; image[7] = 8'hE0; image[8] = 8'hF0;
    image[10] = 8'h52; image[11] = 8'hE0; image[12] = 8'hF0;
    image[14] = 8'd40; image[15] = 8'd2;
    loadAndStart();
    run(12, 7, n, s, "R10");
    chk("R10 result after stall", int'(s), 42);
    chk("R10 enabled cycles unchanged by stall", n, 21);

    for (int r = 0; r < 40; r++) begin
      logic [7:0] x, y; bit sub;
      x = 8'($urandom); y = 8'($urandom); sub = 1'($urandom);
      arithTest(x, y, sub, "R5 random");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule